// File: doc/BRIEF.md
# Second-Level Interrupt Register Group

This block gathers a bank of event lines into one interrupt group with four registers on a simple register-access bus. A raw status view shows the live level of each event input. A mask decides which events may be recorded, and only unmasked event pulses are captured in a sticky identity register. Software clears the identity register with write-one-to-clear writes.

An enable register selects which recorded identity bits count towards a single registered level output. An upstream aggregator combines that output with other groups. Masking acts at capture time and enabling acts at summary time, so a masked event leaves no trace, while an event that is recorded but not enabled stays pending for software to poll.

Top module: `irq_group_regs`

## Requirements
- R1: The byte address selects the register. Offset 0x0 is status, 0x4 is mask, 0x8 is identity and 0xC is enable. A read of mask, identity or enable returns the value currently held.
- R2: After reset the mask is all ones, identity and enable are zero, and the summary output is 0.
- R3: An event input high at a clock edge while its mask bit is 0 sets the matching identity bit at that edge.
- R4: An event arriving while its mask bit is 1 is dropped. Clearing the mask afterwards does not make the identity bit appear.
- R5: A write to the identity register clears each identity bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A write to the mask register replaces all of it and does not change any identity bit.
- R7: A write to the enable register replaces all of it.
- R8: The summary output is 1 exactly when identity AND enable has any bit set. It follows a change of identity or enable one clock later.
- R9: A read of the status register returns the present level of the event inputs. Writes to status have no effect.
- R10: Any address other than 0x0, 0x4, 0x8 and 0xC reads as zero. A write there changes no register.
- R11: When an unmasked event and a clearing write hit the same identity bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event inputs, sampled each clock |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address within the group |
| wdata_i | input | NUM_EVT | Write data |
| rdata_o | output | NUM_EVT | Read data, combinational from address |
| irq_o | output | 1 | Registered summary level to the aggregator |

## Verification
Read data is combinational, so the bench checks each read while the strobe is held, before any clock edge. A register write or an event pulse is driven at a falling edge and takes effect at the next rising edge, so register contents are checked by a read after that edge. The summary output is checked twice, one step after the write or event edge and again one edge later. It must still hold the old value at the first check and the new value at the second.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_IDENT  = 2'd2,
    REG_ENABLE = 2'd3
  } reg_id_e;

  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned REG_STRIDE = 4;

  function automatic int unsigned reg_offset(input int unsigned idx);
    return idx * REG_STRIDE;
  endfunction
endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
  import irq_grp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign sel_o[r] = req_i && (addr_i == ADDR_W'(reg_offset(r)));
  end

  // R1
  one_reg_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R10
  idle_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0));
endmodule

// File: rtl/irq_grp_latch.sv
module irq_grp_latch #(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] imr_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] iir_o
);
  logic [NUM_EVT-1:0] iir_q;
  logic [NUM_EVT-1:0] set_v;

  // mask gates capture; set after clear so an event wins the race
  assign set_v = evt_i & ~imr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iir_q <= '0;
    else         iir_q <= (iir_q & ~clr_i) | set_v;
  end

  assign iir_o = iir_q;

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_chk
    // R3 R11
    evt_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[b] && !imr_i[b]) |=> iir_q[b]);
    // R4
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!iir_q[b] && !(evt_i[b] && !imr_i[b])) |=> !iir_q[b]);
    // R5
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[b] && !(evt_i[b] && !imr_i[b])) |=> !iir_q[b]);
  end
endmodule

// File: rtl/irq_grp_summary.sv
module irq_grp_summary #(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] iir_i,
  input  logic [NUM_EVT-1:0] ier_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(iir_i & ier_i);
  end

  assign irq_o = irq_q;

  // R8
  summary_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(iir_i & ier_i)) |=> irq_o);
  // R8
  summary_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(iir_i & ier_i)) |=> !irq_o);
endmodule

// File: rtl/irq_group_regs.sv
module irq_group_regs
  import irq_grp_pkg::*;
#(
  parameter int unsigned NUM_EVT = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] rdata_o,
  output logic               irq_o
);
  localparam int unsigned REG_W = NUM_EVT;

  logic [NUM_REGS-1:0] sel;
  logic                wr;
  logic [REG_W-1:0]    imr_q, ier_q, iir, clr;

  irq_grp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr  = req_i && we_i;
  assign clr = (wr && sel[REG_IDENT]) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '1;
      ier_q <= '0;
    end else begin
      if (wr && sel[REG_MASK])   imr_q <= wdata_i;
      if (wr && sel[REG_ENABLE]) ier_q <= wdata_i;
    end
  end

  irq_grp_latch #(.NUM_EVT(NUM_EVT)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .imr_i  (imr_q),
    .clr_i  (clr),
    .iir_o  (iir)
  );

  irq_grp_summary #(.NUM_EVT(NUM_EVT)) u_summary (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .iir_i  (iir),
    .ier_i  (ier_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel[REG_STATUS]) rdata_o = evt_i;
    if (sel[REG_MASK])   rdata_o = imr_q;
    if (sel[REG_IDENT])  rdata_o = iir;
    if (sel[REG_ENABLE]) rdata_o = ier_q;
  end

  // R6
  mask_wr_keeps_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel[REG_MASK] && (evt_i == '0)) |=> $stable(iir));
  // R7
  enable_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel[REG_ENABLE]) |=> (ier_q == $past(wdata_i)));
  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (sel == '0)) |=> ($stable(imr_q) && $stable(ier_q)));
endmodule

// File: tb/irq_group_regs_bench.sv
module irq_group_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [NE-1:0] wdata_i = '0;
  logic [NE-1:0] rdata_o;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [NE-1:0] m_imr, m_ier, m_iir;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_regs u_irq_group_regs (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [NE-1:0] got, input logic [NE-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [NE-1:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [NE-1:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] v);
    @(negedge clk);
    evt_i = v;
    @(posedge clk); #1;
    evt_i = '0;
    m_iir = m_iir | (v & ~m_imr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NE-1:0] d;
    m_imr = '1; m_ier = '0; m_iir = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R2 reset state
    #1 chk("R2 irq", {31'b0, irq_o}, 32'h0);
    rd(8'h04, d); chk("R2 mask", d, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 ident", d, 32'h0);
    rd(8'h0C, d); chk("R2 enable", d, 32'h0);

    // R10 every unmapped address reads zero, writes ignored
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        rd(8'(a), d); chk("R10 read", d, 32'h0);
      end
    end
    wr(8'h10, 32'h0000_0000); wr(8'h05, 32'h0); wr(8'hFC, 32'hFFFF_FFFF); wr(8'h0D, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R10 mask kept", d, m_imr);
    rd(8'h0C, d); chk("R10 enable kept", d, m_ier);

    // R9 live status, write ignored; masked so nothing latches
    @(negedge clk) evt_i = 32'h1234_5678;
    rd(8'h00, d); chk("R9 status", d, 32'h1234_5678);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R9 status after write", d, 32'h1234_5678);
    @(negedge clk) evt_i = 32'hCAFE_0001;
    rd(8'h00, d); chk("R9 status change", d, 32'hCAFE_0001);
    @(negedge clk) evt_i = '0;

    // R4 masked events dropped and not recovered by unmasking
    pulse(32'hFFFF_FFFF);
    rd(8'h08, d); chk("R4 masked drop", d, 32'h0);
    wr(8'h04, 32'h0); m_imr = '0;
    rd(8'h08, d); chk("R4 unmask no recall", d, 32'h0);

    // R3 per-bit sweep with mask clear
    for (int n = 0; n < NE; n++) begin
      pulse(32'h1 << n);
      rd(8'h08, d); chk("R3 capture", d, m_iir);
    end
    wr(8'h08, 32'hFFFF_FFFF); m_iir = '0;
    rd(8'h08, d); chk("R5 clear all", d, 32'h0);

    // R3 partial mask
    wr(8'h04, 32'hA5A5_A5A5); m_imr = 32'hA5A5_A5A5;
    rd(8'h04, d); chk("R1 mask readback", d, 32'hA5A5_A5A5);
    pulse(32'hFFFF_FFFF);
    rd(8'h08, d); chk("R3 partial mask", d, 32'h5A5A_5A5A);

    // R6 mask writes leave identity alone
    wr(8'h04, 32'h0); m_imr = '0;
    rd(8'h08, d); chk("R6 unmask keep", d, 32'h5A5A_5A5A);
    wr(8'h04, 32'hFFFF_FFFF); m_imr = '1;
    rd(8'h08, d); chk("R6 mask keep", d, 32'h5A5A_5A5A);

    // R5 write-one-to-clear
    wr(8'h08, 32'h0000_FFFF); m_iir = m_iir & ~32'h0000_FFFF;
    rd(8'h08, d); chk("R5 w1c", d, 32'h5A5A_0000);
    wr(8'h08, 32'h0); 
    rd(8'h08, d); chk("R5 zero write", d, 32'h5A5A_0000);

    // R11 event beats clear on the same bit
    wr(8'h04, 32'h0); m_imr = '0;
    @(negedge clk);
    evt_i = 32'h0000_0001;
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h08; wdata_i = 32'h0002_0001;
    @(posedge clk); #1;
    evt_i = '0; req_i = 1'b0; we_i = 1'b0;
    rd(8'h08, d); chk("R11 event wins", d, 32'h5A58_0001);
    m_iir = 32'h5A58_0001;

    // R7 R8 enable and summary timing
    #1 chk("R8 idle", {31'b0, irq_o}, 32'h0);
    wr(8'h0C, 32'h0000_0001);
    chk("R8 enable +0", {31'b0, irq_o}, 32'h0);
    @(posedge clk); #1 chk("R8 enable +1", {31'b0, irq_o}, 32'h1);
    rd(8'h0C, d); chk("R7 enable readback", d, 32'h0000_0001);
    wr(8'h0C, 32'h8000_0000);
    chk("R8 disable +0", {31'b0, irq_o}, 32'h1);
    @(posedge clk); #1 chk("R8 disable +1", {31'b0, irq_o}, 32'h0);
    rd(8'h0C, d); chk("R7 enable replaced", d, 32'h8000_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    @(posedge clk); #1 chk("R8 all enabled", {31'b0, irq_o}, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF); m_iir = '0;
    chk("R8 clear +0", {31'b0, irq_o}, 32'h1);
    @(posedge clk); #1 chk("R8 clear +1", {31'b0, irq_o}, 32'h0);

    // R8 event path: capture edge then summary edge
    pulse(32'h0000_0080);
    chk("R8 event +0", {31'b0, irq_o}, 32'h0);
    @(posedge clk); #1 chk("R8 event +1", {31'b0, irq_o}, 32'h1);
    rd(8'h08, d); chk("R3 event ident", d, 32'h0000_0080);

    finish_run();
  end
endmodule